// File: doc/BRIEF.md
# Vector In-Cache Instruction Sequencer

This block sits in a cache controller and turns one vector compute instruction into a stream of block-sized operations. An instruction carries an opcode, two source addresses, a destination address, a byte length and a search key. After the handshake the block offers one operation per cycle. Each operation covers one cache block. Addresses rise by one block from one operation to the next. The final operation carries a byte mask for a partial block. A search instruction repeats its key on every operation. Each operation is tagged with the single cache level that executes it. A second flag sends the operation to the controller's near-place vector unit when its operands cannot share bit-lines.

A length of zero, or a length beyond the supported maximum, is refused with a one-cycle exception pulse so that software can split the work. Coherence requests take priority over compute. While one is present no operation is offered. The first operation offered afterwards is flagged so the line is fetched again. A fence input holds back new instructions until every issued operation has reported completion.

Top module: `ccseq_top`

## Requirements
- R1: An instruction is taken on a cycle where `ins_valid` and `ins_ready` are both high. `ins_ready` is low while an instruction is being sequenced, and the first operation is offered in the cycle after the handshake.
- R2: An instruction of L bytes yields ceil(L/64) operations. Operation k carries source and destination addresses equal to the instruction's addresses plus 64*k. Only the final operation has `op_last` set, and `ins_done` pulses for one cycle in the cycle after the final operation is accepted.
- R3: A length of 0 or greater than 4096 produces no operation, and `exc_out` pulses high for one cycle in the cycle after the handshake.
- R4: Bit i of `op_mask` is set exactly when i < L - 64*k, so every operation but the last has all 64 bits set.
- R5: Opcode encoding is AND=0, OR=1, XOR=2, NOT=3, COPY=4, CMP=5, SEARCH=6. For SEARCH every operation carries the instruction's key on `op_key`, and for every other opcode `op_key` is zero.
- R6: Bit i of `lvl_hold` means level i holds all operands, with bit 0 the level closest to the core. `op_level` is one-hot at the lowest set bit sampled at the handshake, or at bit 2 (the last level) when no bit is set.
- R7: `op_near` is 1 when bits [11:0] of the first source differ from those of the destination. For the two-source opcodes AND, OR, XOR and CMP it is also 1 when bits [11:0] of the second source differ from the destination's.
- R8: While `coh_req` is high, `op_valid` is low. `coh_ack` in each cycle equals `coh_req` of the previous cycle.
- R9: `op_refetch` is 1 on the first operation offered after a cycle in which `coh_req` was high during an instruction, and 0 on all other operations.
- R10: While `fence` is high and any accepted operation has not yet been matched by an `op_cmpl` pulse, `ins_ready` stays low.
- R11: After reset `ins_ready` is 1, and `op_valid`, `exc_out`, `ins_done` and `coh_ack` are 0.
- R12: An offered operation that is not accepted stays offered with unchanged fields until it is accepted, unless a coherence request withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Sequencer can take an instruction |
| ins_opcode | input | 3 | Operation code |
| ins_src_a | input | 32 | First source byte address |
| ins_src_b | input | 32 | Second source byte address |
| ins_dst | input | 32 | Destination byte address |
| ins_len | input | 16 | Operand length in bytes |
| ins_key | input | 64 | Search key |
| lvl_hold | input | 3 | Per-level flag: level holds all operands |
| fence | input | 1 | Hold new instructions until issued operations complete |
| op_valid | output | 1 | Operation offered |
| op_ready | input | 1 | Downstream accepts the operation |
| op_opcode | output | 3 | Operation code |
| op_src_a | output | 32 | First source block address |
| op_src_b | output | 32 | Second source block address |
| op_dst | output | 32 | Destination block address |
| op_mask | output | 64 | Valid byte mask within the block |
| op_key | output | 64 | Search key for this block |
| op_level | output | 3 | One-hot executing cache level |
| op_near | output | 1 | Execute in the near-place unit, not in place |
| op_refetch | output | 1 | Line must be fetched again before computing |
| op_last | output | 1 | Final operation of the instruction |
| op_cmpl | input | 1 | One issued operation has completed |
| ins_done | output | 1 | Instruction fully issued |
| exc_out | output | 1 | Instruction refused for its length |
| coh_req | input | 1 | Coherence request pending |
| coh_ack | output | 1 | Coherence request acknowledged |

## Verification
Operation k of an instruction is due k+1 cycles after the handshake when nothing stalls it. Each stall cycle and each coherence cycle pushes it back by one. The bench therefore does not count cycles to find operations: it compares every handshake it observes, at the falling edge, with the model for the next index. `exc_out` and `coh_ack` are each due exactly one cycle after their cause. `ins_done` is due one cycle after the final accepted operation. The bench samples these at the first falling edge after the rising edge that registers them. Inputs change just after the rising edge, so a value seen at a falling edge is the value the next rising edge will act on.

// File: rtl/ccseq_pkg.sv
package ccseq_pkg;

   typedef enum logic [2:0] {
      CC_AND    = 3'd0,
      CC_OR     = 3'd1,
      CC_XOR    = 3'd2,
      CC_NOT    = 3'd3,
      CC_COPY   = 3'd4,
      CC_CMP    = 3'd5,
      CC_SEARCH = 3'd6
   } cc_opc_e;

   // Opcodes that read the second source operand.
   function automatic logic uses_src_b(input logic [2:0] opc);
      return (opc == CC_AND) || (opc == CC_OR) || (opc == CC_XOR) || (opc == CC_CMP);
   endfunction

endpackage

// File: rtl/ccseq_level_pick.sv
module ccseq_level_pick #(
   parameter int NLVL = 3
) (
   input  logic [NLVL-1:0] hold,
   output logic [NLVL-1:0] pick
);
   logic [NLVL-1:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < NLVL; i++) begin : g_lvl
         if (i < NLVL - 1) begin : g_upper
            assign seen[i+1] = seen[i] | hold[i];
            assign pick[i]   = hold[i] & ~seen[i];
         end else begin : g_last
            // Last level is the fallback when no level holds all operands.
            assign pick[i] = ~seen[i];
         end
      end
   endgenerate
endmodule

// File: rtl/ccseq_locality.sv
module ccseq_locality #(
   parameter int PAGE_BITS = 12
) (
   input  logic [PAGE_BITS-1:0] a_low,
   input  logic [PAGE_BITS-1:0] b_low,
   input  logic [PAGE_BITS-1:0] d_low,
   input  logic                 two_src,
   output logic                 near
);
   always_comb begin
      near = (a_low != d_low);
      if (two_src && (b_low != d_low)) near = 1'b1;
   end
endmodule

// File: rtl/ccseq_mask_gen.sv
module ccseq_mask_gen #(
   parameter int BLK  = 64,
   parameter int LENW = 16
) (
   input  logic [LENW-1:0] rem,
   output logic [BLK-1:0]  mask
);
   always_comb begin
      for (int i = 0; i < BLK; i++) begin
         mask[i] = (rem > LENW'(i));
      end
   end
endmodule

// File: rtl/ccseq_top.sv
module ccseq_top #(
   parameter int AW        = 32,
   parameter int LENW      = 16,
   parameter int KEYW      = 64,
   parameter int NLVL      = 3,
   parameter int BLK       = 64,
   parameter int MAX_LEN   = 4096,
   parameter int PAGE_BITS = 12,
   parameter int OUTW      = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ins_valid,
   output logic            ins_ready,
   input  logic [2:0]      ins_opcode,
   input  logic [AW-1:0]   ins_src_a,
   input  logic [AW-1:0]   ins_src_b,
   input  logic [AW-1:0]   ins_dst,
   input  logic [LENW-1:0] ins_len,
   input  logic [KEYW-1:0] ins_key,
   input  logic [NLVL-1:0] lvl_hold,
   input  logic            fence,
   output logic            op_valid,
   input  logic            op_ready,
   output logic [2:0]      op_opcode,
   output logic [AW-1:0]   op_src_a,
   output logic [AW-1:0]   op_src_b,
   output logic [AW-1:0]   op_dst,
   output logic [BLK-1:0]  op_mask,
   output logic [KEYW-1:0] op_key,
   output logic [NLVL-1:0] op_level,
   output logic            op_near,
   output logic            op_refetch,
   output logic            op_last,
   input  logic            op_cmpl,
   output logic            ins_done,
   output logic            exc_out,
   input  logic            coh_req,
   output logic            coh_ack
);
   import ccseq_pkg::*;

   localparam int BOFF     = $clog2(BLK);
   localparam int NOPS_MAX = MAX_LEN / BLK;
   localparam int KW       = $clog2(NOPS_MAX) + 1;

   // Elaboration-time parameter checks.
   generate
      if ((BLK & (BLK - 1)) != 0) begin : g_bad_blk
         $error("BLK must be a power of two");
      end
      if ((MAX_LEN % BLK) != 0) begin : g_bad_max
         $error("MAX_LEN must be a multiple of BLK");
      end
      if (MAX_LEN >= (1 << LENW)) begin : g_bad_lenw
         $error("LENW too narrow for MAX_LEN");
      end
      if (PAGE_BITS > AW) begin : g_bad_page
         $error("PAGE_BITS exceeds AW");
      end
      if (NLVL < 2) begin : g_bad_nlvl
         $error("NLVL must be at least 2");
      end
   endgenerate

   // Instruction state
   logic            busy;
   logic [2:0]      r_opc;
   logic [AW-1:0]   r_a, r_b, r_d;
   logic [LENW-1:0] r_len;
   logic [KEYW-1:0] r_key;
   logic [NLVL-1:0] r_lvl;
   logic            r_near;
   logic [KW-1:0]   r_k;
   logic            r_done, r_exc, r_ack, r_ref;
   logic [OUTW-1:0] r_outst;

   logic            accept, len_bad, fence_blk, hs, last_op;
   logic [LENW-1:0] off_len, rem;
   logic [AW-1:0]   off_adr;
   logic [NLVL-1:0] lvl_pick;
   logic            near_now;

   ccseq_level_pick #(.NLVL(NLVL)) u_lvl (
      .hold (lvl_hold),
      .pick (lvl_pick)
   );

   ccseq_locality #(.PAGE_BITS(PAGE_BITS)) u_loc (
      .a_low   (ins_src_a[PAGE_BITS-1:0]),
      .b_low   (ins_src_b[PAGE_BITS-1:0]),
      .d_low   (ins_dst[PAGE_BITS-1:0]),
      .two_src (uses_src_b(ins_opcode)),
      .near    (near_now)
   );

   ccseq_mask_gen #(.BLK(BLK), .LENW(LENW)) u_mask (
      .rem  (rem),
      .mask (op_mask)
   );

   assign len_bad   = (ins_len == '0) || (ins_len > LENW'(MAX_LEN));
   assign fence_blk = fence && (r_outst != '0);
   assign ins_ready = !busy && !fence_blk;
   assign accept    = ins_valid && ins_ready;

   assign off_len   = LENW'(r_k) << BOFF;
   assign off_adr   = AW'(r_k) << BOFF;
   assign rem       = r_len - off_len;
   assign last_op   = (rem <= LENW'(BLK));

   // Coherence has priority: no operation is offered while it is pending.
   assign op_valid  = busy && !coh_req;
   assign hs        = op_valid && op_ready;

   assign op_opcode  = r_opc;
   assign op_src_a   = r_a + off_adr;
   assign op_src_b   = r_b + off_adr;
   assign op_dst     = r_d + off_adr;
   assign op_key     = (r_opc == CC_SEARCH) ? r_key : '0;
   assign op_level   = r_lvl;
   assign op_near    = r_near;
   assign op_refetch = r_ref;
   assign op_last    = last_op;
   assign ins_done   = r_done;
   assign exc_out    = r_exc;
   assign coh_ack    = r_ack;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         r_opc  <= '0;
         r_a    <= '0;
         r_b    <= '0;
         r_d    <= '0;
         r_len  <= '0;
         r_key  <= '0;
         r_lvl  <= '0;
         r_near <= 1'b0;
         r_k    <= '0;
         r_done <= 1'b0;
         r_exc  <= 1'b0;
         r_ack  <= 1'b0;
         r_ref  <= 1'b0;
      end else begin
         r_done <= 1'b0;
         r_exc  <= 1'b0;
         r_ack  <= coh_req;
         if (accept) begin
            if (len_bad) begin
               r_exc <= 1'b1;
            end else begin
               busy   <= 1'b1;
               r_opc  <= ins_opcode;
               r_a    <= ins_src_a;
               r_b    <= ins_src_b;
               r_d    <= ins_dst;
               r_len  <= ins_len;
               r_key  <= ins_key;
               r_lvl  <= lvl_pick;
               r_near <= near_now;
               r_k    <= '0;
               r_ref  <= 1'b0;
            end
         end else if (hs) begin
            r_ref <= 1'b0;
            if (last_op) begin
               busy   <= 1'b0;
               r_done <= 1'b1;
            end else begin
               r_k <= r_k + 1'b1;
            end
         end else if (busy && coh_req) begin
            r_ref <= 1'b1;
         end
      end
   end

   // Outstanding operation count for the fence.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_outst <= '0;
      end else begin
         case ({hs, op_cmpl && (r_outst != '0)})
            2'b10:   r_outst <= r_outst + 1'b1;
            2'b01:   r_outst <= r_outst - 1'b1;
            default: r_outst <= r_outst;
         endcase
      end
   end

   // R12: a stalled operation keeps its fields
   a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_ready) |=> (coh_req || (op_valid && $stable(op_src_a) && $stable(op_dst))));

   // R4: only the last operation may carry a partial mask
   a_r4_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_last) |-> (&op_mask));

   // R6: exactly one executing level
   a_r6_one_level: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> ($countones(op_level) == 1));

   // R8: coherence request acknowledged one cycle later
   a_r8_coh_ack: assert property (@(posedge clk) disable iff (!rst_n)
      coh_req |=> coh_ack);

   // R2: completion follows an accepted final operation
   a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      ins_done |-> $past(op_valid && op_ready && op_last));

   // R3: an exception is never paired with an operation
   a_r3_exc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      exc_out |-> !op_valid);

   // R1: a new instruction is never taken mid-sequence
   a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> !ins_ready);
endmodule

// File: tb/ccseq_top_bench.sv
module ccseq_top_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ins_valid = 1'b0;
   logic         ins_ready;
   logic [2:0]   ins_opcode = '0;
   logic [31:0]  ins_src_a = '0, ins_src_b = '0, ins_dst = '0;
   logic [15:0]  ins_len = '0;
   logic [63:0]  ins_key = '0;
   logic [2:0]   lvl_hold = '0;
   logic         fence = 1'b0;
   logic         op_valid;
   logic         op_ready = 1'b0;
   logic [2:0]   op_opcode;
   logic [31:0]  op_src_a, op_src_b, op_dst;
   logic [63:0]  op_mask, op_key;
   logic [2:0]   op_level;
   logic         op_near, op_refetch, op_last;
   logic         op_cmpl = 1'b0;
   logic         ins_done, exc_out;
   logic         coh_req = 1'b0;
   logic         coh_ack;

   ccseq_top u_ccseq_top (.*);

   always #4 clk = ~clk;

   int total = 0, bad = 0;
   int k = 0, nops = 0, bench_out = 0;
   bit in_flight = 0, bench_ref = 0, prev_coh = 0;
   bit rand_en = 0, coh_en = 0, cmpl_en = 0;
   logic [2:0]  e_op;
   logic [31:0] e_a, e_b, e_d;
   logic [15:0] e_len;
   logic [63:0] e_key;
   logic [2:0]  e_hold;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] f_level(input logic [2:0] h);
      if (h[0]) return 3'b001;
      if (h[1]) return 3'b010;
      return 3'b100;
   endfunction

   function automatic logic f_near(input logic [2:0] opc, input logic [31:0] a, b, d);
      logic two;
      two = (opc == 3'd0) || (opc == 3'd1) || (opc == 3'd2) || (opc == 3'd5);
      return (a[11:0] != d[11:0]) || (two && (b[11:0] != d[11:0]));
   endfunction

   function automatic logic [63:0] f_mask(input int rem);
      if (rem >= 64) return '1;
      return (64'd1 << rem) - 64'd1;
   endfunction

   // Random drive of handshake, coherence and completion, just after the edge.
   always @(posedge clk) begin
      #1;
      if (rand_en) begin
         op_ready = ($urandom % 4) != 0;
         coh_req  = coh_en && (($urandom % 16) == 0);
      end
      op_cmpl = cmpl_en && (bench_out > 0) && (($urandom % 2) == 0);
      if (op_cmpl) bench_out--;
   end

   // Monitor at the falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (coh_req) chk(!op_valid, "R8 op withheld during coherence", op_valid, 0);
         chk(coh_ack == prev_coh, "R8 coh_ack", coh_ack, prev_coh);
         if (op_valid && op_ready) begin
            chk(op_src_a == e_a + 32'(k * 64), "R2 src_a", op_src_a, e_a + 32'(k * 64));
            chk(op_src_b == e_b + 32'(k * 64), "R2 src_b", op_src_b, e_b + 32'(k * 64));
            chk(op_dst == e_d + 32'(k * 64), "R2 dst", op_dst, e_d + 32'(k * 64));
            chk(op_opcode == e_op, "R2 opcode", op_opcode, e_op);
            chk(op_last == (k == nops - 1), "R2 last", op_last, (k == nops - 1));
            chk(op_mask == f_mask(int'(e_len) - k * 64), "R4 mask", op_mask, f_mask(int'(e_len) - k * 64));
            chk(op_key == ((e_op == 3'd6) ? e_key : 64'd0), "R5 key", op_key, (e_op == 3'd6) ? e_key : 64'd0);
            chk(op_level == f_level(e_hold), "R6 level", op_level, f_level(e_hold));
            chk(op_near == f_near(e_op, e_a, e_b, e_d), "R7 near", op_near, f_near(e_op, e_a, e_b, e_d));
            chk(op_refetch == bench_ref, "R9 refetch", op_refetch, bench_ref);
            bench_ref = 0;
            bench_out++;
            if (op_last) in_flight = 0;
            k++;
         end
         if (coh_req && in_flight) bench_ref = 1;
         prev_coh = coh_req;
      end
   end

   task automatic issue(input logic [2:0] opc, input logic [31:0] a, b, d,
                        input logic [15:0] len, input logic [63:0] key, input logic [2:0] hold);
      int guard;
      bit lbad;
      guard = 0;
      @(negedge clk);
      while (!ins_ready) @(negedge clk);
      ins_valid = 1; ins_opcode = opc; ins_src_a = a; ins_src_b = b; ins_dst = d;
      ins_len = len; ins_key = key; lvl_hold = hold;
      lbad = (len == 0) || (len > 16'd4096);
      @(posedge clk);
      #1;
      ins_valid = 0;
      lvl_hold = ~hold;
      e_op = opc; e_a = a; e_b = b; e_d = d; e_len = len; e_key = key; e_hold = hold;
      k = 0; nops = (int'(len) + 63) / 64; bench_ref = 0;
      if (lbad) begin
         @(negedge clk);
         chk(exc_out == 1, "R3 exception pulse", exc_out, 1);
         chk(!op_valid, "R3 no operation", op_valid, 0);
         @(negedge clk);
         chk(exc_out == 0, "R3 pulse width", exc_out, 0);
         chk(!op_valid && k == 0, "R3 still no operation", op_valid, 0);
      end else begin
         in_flight = 1;
         @(negedge clk);
         chk(!ins_ready, "R1 ready low while busy", ins_ready, 0);
         while (!ins_done && guard < 20000) begin
            @(negedge clk);
            guard++;
         end
         chk(k == nops, "R2 op count at done", k, nops);
         @(negedge clk);
         chk(!ins_done, "R2 done single cycle", ins_done, 0);
      end
   endtask

   initial begin
      int wd;
      wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=done", wd);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] a, b, d;
      logic [15:0] len;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ins_ready == 1, "R11 reset ready", ins_ready, 1);
      chk(op_valid == 0, "R11 reset op_valid", op_valid, 0);
      chk(exc_out == 0 && ins_done == 0, "R11 reset pulses", {exc_out, ins_done}, 0);
      chk(coh_ack == 0, "R11 reset coh_ack", coh_ack, 0);
      rst_n = 1;

      // Directed corners with the downstream always ready.
      op_ready = 1;
      cmpl_en = 1;
      issue(3'd0, 32'h1000_0040, 32'h2000_0040, 32'h3000_0040, 16'd1,    64'h0, 3'b001);
      issue(3'd1, 32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 16'd64,   64'h0, 3'b010);
      issue(3'd6, 32'h1000_0000, 32'h0,         32'h3000_0010, 16'd65,   64'hDEAD_BEEF_0123_4567, 3'b110);
      issue(3'd4, 32'h1111_1000, 32'h0,         32'h2222_2000, 16'd4096, 64'h5, 3'b000);
      issue(3'd2, 32'h0,         32'h0,         32'h0,         16'd0,    64'h0, 3'b001);
      issue(3'd2, 32'h0,         32'h0,         32'h0,         16'd4097, 64'h0, 3'b001);
      issue(3'd3, 32'h1000_0123, 32'h5000_0777, 32'h3000_0123, 16'd130,  64'h0, 3'b100);

      // R10: fence holds back new instructions while operations are outstanding.
      cmpl_en = 0;
      issue(3'd5, 32'h4000_0000, 32'h5000_0000, 32'h6000_0000, 16'd200, 64'h0, 3'b010);
      fence = 1;
      @(negedge clk);
      @(negedge clk);
      chk(!ins_ready, "R10 fence blocks", ins_ready, 0);
      cmpl_en = 1;
      while (bench_out > 0) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(ins_ready, "R10 fence released", ins_ready, 1);
      fence = 0;

      // Random phase with stalls and coherence traffic.
      rand_en = 1;
      coh_en = 1;
      for (int n = 0; n < 40; n++) begin
         a = $urandom; b = $urandom; d = $urandom;
         if ($urandom % 2) begin b[11:0] = a[11:0]; d[11:0] = a[11:0]; end
         case ($urandom % 8)
            0:       len = 16'd4097 + 16'($urandom % 100);
            1:       len = 16'd64 * 16'(1 + $urandom % 8);
            default: len = 16'd1 + 16'($urandom % 4096);
         endcase
         issue(3'($urandom % 7), a, b, d, len, {$urandom, $urandom}, 3'($urandom));
      end
      rand_en = 0;
      coh_en = 0;
      coh_req = 0;
      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule